// File: doc/BRIEF.md
# Burst Gate and Trigger Generator

This block produces a periodic enable gate that switches a pattern stream on and off in bursts. It runs on the system clock and advances its timing only on a one-clock timebase strobe that arrives once per microsecond, so every length it handles is a whole number of microseconds. Two lengths come from configuration: the full burst period and the part of that period during which the gate is open. A burst can begin either from the block's own period counter or from a rising edge on an external trigger input, chosen by a mode input.

Each time the gate opens, a one-clock trigger pulse is emitted alongside it so that downstream equipment can align to the burst. A separate sync output serves as a timing reference. It is either a square wave at one eighth of the clock rate, or a registered copy of a strobe that the pattern source raises at a chosen position in its sequence. Configuration is sampled only when a burst begins, so software can rewrite it at any time without tearing the burst in progress.

Top module: `burst_gate_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `burst_gate`, `burst_trig` and `sync_out` are 0. The tick counters are cleared, so the first burst after reset always runs from position zero with full lengths.
- R2: With `ext_mode`=0, once a burst has begun the gate is high for exactly E timebase ticks and bursts repeat every C ticks. E and C are the settings latched at the start of the burst. The gate changes one clock after the tick that causes the change.
- R3: Settings are made legal when they are latched. A period below 2 is taken as 2. An enable length of 0 is taken as 1. An enable length that is not below the period is taken as the period minus 1.
- R4: `burst_trig` is high for one clock, in exactly the clocks where `burst_gate` goes from 0 to 1, and never at any other time.
- R5: With `ext_mode`=1 and the gate low, a rising edge on `ext_trig_in` raises the gate on the next clock. The gate stays open for E ticks and then stays low until the next rising edge.
- R6: With `ext_mode`=1, a rising edge on `ext_trig_in` while the gate is high is ignored. The burst neither restarts nor lengthens, and no trigger pulse is emitted.
- R7: Changes to `cfg_cycle_us` and `cfg_enable_us` have no effect on the burst in progress. They are applied at the next burst start.
- R8: With `ext_mode`=0 and no burst running since reset, the first tick starts a burst.
- R9: With `sync_pat_mode`=0, `sync_out` is a square wave with a period of 8 clocks that is high for 4 clocks of each period.
- R10: With `sync_pat_mode`=1, `sync_out` equals the value `pat_pos_strobe` had at the previous clock edge.
- R11: With `ext_mode`=0, `ext_trig_in` has no effect. With `ext_mode`=1 and the block idle, ticks do not start a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-clock strobe, once per microsecond |
| cfg_cycle_us | input | 16 | Burst period in microseconds |
| cfg_enable_us | input | 16 | Gate-open length in microseconds |
| ext_mode | input | 1 | 1: bursts started by external trigger; 0: internal period counter |
| ext_trig_in | input | 1 | External burst trigger, rising edge active |
| sync_pat_mode | input | 1 | 1: sync follows pattern strobe; 0: clock divided by 8 |
| pat_pos_strobe | input | 1 | Strobe from the pattern source at the chosen position |
| burst_gate | output | 1 | Burst enable gate |
| burst_trig | output | 1 | One-clock pulse at each gate rise |
| sync_out | output | 1 | Sync reference output |

## Verification
The hardest situation to reach is a configuration rewrite that lands in the middle of a burst, mixed with an illegal length pair. Only the next burst may reflect it, and it must be clamped. The stimulus draws new period and enable values, including enable lengths above the period and zero, at random clocks while ticks arrive with random gaps. A bench model that latches settings only at its own burst starts predicts every clock. In external mode, trigger edges are fired at random, so many of them land while the gate is open. This exercises the ignore rule together with bursts that end and go idle.

// File: rtl/gate_pkg.sv
package gate_pkg;

    // Width of every microsecond count (period, enable length, position)
    localparam int US_W = 16;
    // log2 of the sync clock divider
    localparam int SYNC_DIV_LOG = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [US_W-1:0] cycle;
        logic [US_W-1:0] enable;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{cycle: US_W'(2), enable: US_W'(1)};

    // Turn any requested pair into one the timer can run
    function automatic burst_cfg_t legalize(input burst_cfg_t req);
        burst_cfg_t r;
        r.cycle  = (req.cycle < US_W'(2)) ? US_W'(2) : req.cycle;
        r.enable = (req.enable == '0) ? US_W'(1) : req.enable;
        if (r.enable >= r.cycle) begin
            r.enable = r.cycle - US_W'(1);
        end
        return r;
    endfunction

endpackage

// File: rtl/bg_edge_detect.sv
module bg_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= din;
        end
    end

    assign rise = din & ~prev_q;
endmodule

// File: rtl/bg_burst_timer.sv
module bg_burst_timer
    import gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ext_mode,
    input  logic       ext_start,
    input  burst_cfg_t cfg_req,
    output logic       gate,
    output logic       trig,
    output burst_cfg_t cfg_live
);
    phase_e          ph_q, ph_n;
    logic [US_W-1:0] pos_q, pos_n, pos_inc;
    burst_cfg_t      act_q, act_n;
    logic            start;

    assign pos_inc = pos_q + US_W'(1);

    always_comb begin
        ph_n  = ph_q;
        pos_n = pos_q;
        act_n = act_q;
        start = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (ext_mode) begin
                    start = ext_start;
                end else begin
                    start = tick;
                end
            end
            PH_ON: begin
                if (tick) begin
                    pos_n = pos_inc;
                    if (pos_inc == act_q.enable) begin
                        ph_n = ext_mode ? PH_IDLE : PH_OFF;
                    end
                end
            end
            PH_OFF: begin
                if (ext_mode && ext_start) begin
                    start = 1'b1;
                end else if (tick) begin
                    pos_n = pos_inc;
                    if (pos_inc == act_q.cycle) begin
                        if (ext_mode) begin
                            ph_n = PH_IDLE;
                        end else begin
                            start = 1'b1;
                        end
                    end
                end
            end
            default: ph_n = PH_IDLE;
        endcase
        if (start) begin
            ph_n  = PH_ON;
            pos_n = '0;
            act_n = legalize(cfg_req);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            pos_q <= '0;
            act_q <= CFG_RESET;
            gate  <= 1'b0;
            trig  <= 1'b0;
        end else begin
            ph_q  <= ph_n;
            pos_q <= pos_n;
            act_q <= act_n;
            gate  <= (ph_n == PH_ON);
            trig  <= start;
        end
    end

    assign cfg_live = act_q;
endmodule

// File: rtl/bg_sync_gen.sv
module bg_sync_gen #(
    parameter int DIV_LOG = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pat_mode,
    input  logic pat_strobe,
    output logic sync
);
    logic [DIV_LOG-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            sync  <= 1'b0;
        end else begin
            div_q <= div_q + DIV_LOG'(1);
            sync  <= pat_mode ? pat_strobe : div_q[DIV_LOG-1];
        end
    end
endmodule

// File: rtl/burst_gate_gen.sv
module burst_gate_gen
    import gate_pkg::*;
#(
    parameter int DIV_LOG = SYNC_DIV_LOG
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_us,
    input  logic [US_W-1:0] cfg_cycle_us,
    input  logic [US_W-1:0] cfg_enable_us,
    input  logic            ext_mode,
    input  logic            ext_trig_in,
    input  logic            sync_pat_mode,
    input  logic            pat_pos_strobe,
    output logic            burst_gate,
    output logic            burst_trig,
    output logic            sync_out
);
    logic       ext_rise;
    burst_cfg_t cfg_req;
    burst_cfg_t live_cfg;

    assign cfg_req = '{cycle: cfg_cycle_us, enable: cfg_enable_us};

    bg_edge_detect u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_trig_in),
        .rise (ext_rise)
    );

    bg_burst_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_us),
        .ext_mode  (ext_mode),
        .ext_start (ext_rise),
        .cfg_req   (cfg_req),
        .gate      (burst_gate),
        .trig      (burst_trig),
        .cfg_live  (live_cfg)
    );

    bg_sync_gen #(.DIV_LOG(DIV_LOG)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pat_mode   (sync_pat_mode),
        .pat_strobe (pat_pos_strobe),
        .sync       (sync_out)
    );
endmodule

// File: rtl/bg_checker.sv
module bg_checker
    import gate_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_us,
    input logic       sync_pat_mode,
    input logic       pat_pos_strobe,
    input logic       burst_gate,
    input logic       burst_trig,
    input logic       sync_out,
    input burst_cfg_t live_cfg
);
    // R1: outputs quiet right after a reset clock
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!burst_gate && !burst_trig && !sync_out));

    // R4: every gate rise carries a trigger pulse
    a_r4_trig_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_gate) |-> burst_trig);

    // R4: a trigger pulse only where the gate has just risen
    a_r4_trig_only_rise: assert property (@(posedge clk) disable iff (rst)
        burst_trig |-> (burst_gate && !$past(burst_gate)));

    // R2: the gate closes only after a timebase tick
    a_r2_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(burst_gate) |-> $past(tick_us));

    // R3: the running pair is always legal
    a_r3_legal_pair: assert property (@(posedge clk) disable iff (rst)
        (live_cfg.enable != '0) && (live_cfg.enable < live_cfg.cycle));

    // R10: pattern sync is the strobe one clock later
    a_r10_pattern_follow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sync_pat_mode)) |-> (sync_out == $past(pat_pos_strobe)));
endmodule

bind burst_gate_gen bg_checker chk_i (
    .clk            (clk),
    .rst            (rst),
    .tick_us        (tick_us),
    .sync_pat_mode  (sync_pat_mode),
    .pat_pos_strobe (pat_pos_strobe),
    .burst_gate     (burst_gate),
    .burst_trig     (burst_trig),
    .sync_out       (sync_out),
    .live_cfg       (live_cfg)
);

// File: tb/burst_gate_gen_tb_top.sv
module burst_gate_gen_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         tick_us;
    logic [W-1:0] cfg_cycle_us;
    logic [W-1:0] cfg_enable_us;
    logic         ext_mode;
    logic         ext_trig_in;
    logic         sync_pat_mode;
    logic         pat_pos_strobe;
    logic         burst_gate;
    logic         burst_trig;
    logic         sync_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model state
    bit m_run, m_on, m_prev_e;
    int m_k, m_cyc, m_en;

    always #5 clk = ~clk;

    burst_gate_gen dut_i (
        .clk            (clk),
        .rst            (rst),
        .tick_us        (tick_us),
        .cfg_cycle_us   (cfg_cycle_us),
        .cfg_enable_us  (cfg_enable_us),
        .ext_mode       (ext_mode),
        .ext_trig_in    (ext_trig_in),
        .sync_pat_mode  (sync_pat_mode),
        .pat_pos_strobe (pat_pos_strobe),
        .burst_gate     (burst_gate),
        .burst_trig     (burst_trig),
        .sync_out       (sync_out)
    );

    function automatic int want_cyc(input int c);
        return (c < 2) ? 2 : c;
    endfunction

    function automatic int want_en(input int c, input int e);
        int lc = want_cyc(c);
        int le = (e < 1) ? 1 : e;
        return (le >= lc) ? lc - 1 : le;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_run = 0; m_on = 0; m_prev_e = 0; m_k = 0; m_cyc = 2; m_en = 1;
    endtask

    // returns expected trigger for this clock
    function automatic bit model_step(input bit t, input bit e);
        bit rise = e && !m_prev_e;
        bit st = 0;
        m_prev_e = e;
        if (!m_run) begin
            st = ext_mode ? rise : t;
        end else if (m_on) begin
            if (t) begin
                m_k++;
                if (m_k == m_en) begin
                    m_on = 0;
                    if (ext_mode) m_run = 0;
                end
            end
        end else begin
            if (ext_mode && rise) st = 1;
            else if (t) begin
                m_k++;
                if (m_k == m_cyc) begin
                    if (ext_mode) m_run = 0;
                    else st = 1;
                end
            end
        end
        if (st) begin
            m_run = 1; m_on = 1; m_k = 0;
            m_cyc = want_cyc(int'(cfg_cycle_us));
            m_en  = want_en(int'(cfg_cycle_us), int'(cfg_enable_us));
        end
        return st;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1; tick_us = 0; ext_trig_in = 0; pat_pos_strobe = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "gate in reset", int'(burst_gate), 0);
        chk("R1", "trig in reset", int'(burst_trig), 0);
        chk("R1", "sync in reset", int'(sync_out), 0);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic step(input bit t, input bit e, input bit s, input string tag);
        bit et;
        @(negedge clk);
        tick_us = t; ext_trig_in = e; pat_pos_strobe = s;
        @(posedge clk);
        #1;
        et = model_step(t, e);
        chk(tag, "gate", int'(burst_gate), int'(m_on));
        chk("R4", "trig", int'(burst_trig), int'(et));
        if (sync_pat_mode) chk("R10", "pattern sync", int'(sync_out), int'(s));
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h5eed_0b17;
        bit sv [32];
        void'($urandom(seed));
        rst = 1; tick_us = 0; ext_trig_in = 0; pat_pos_strobe = 0;
        ext_mode = 0; sync_pat_mode = 0;
        cfg_cycle_us = 16'd5; cfg_enable_us = 16'd2;

        // R1 reset state, then R9 divide-by-8 sync and R11 ext ignored in internal mode
        do_reset();
        for (int i = 0; i < 32; i++) begin
            step(1'b0, (i % 6) < 3, 1'b0, "R11");
            sv[i] = sync_out;
        end
        for (int i = 0; i < 28; i++) chk("R9", "div8 half period", int'(sv[i + 4]), int'(!sv[i]));
        begin
            int hi = 0;
            for (int i = 0; i < 8; i++) hi += int'(sv[i]);
            chk("R9", "div8 high clocks", hi, 4);
        end

        // R8 first tick starts burst; R2 directed lengths
        step(1'b1, 1'b0, 1'b0, "R8");
        chk("R8", "gate after first tick", int'(burst_gate), 1);
        for (int i = 0; i < 40; i++) step(i % 2 == 0, 1'b0, 1'b0, "R2");

        // R3 directed clamps
        cfg_cycle_us = 16'd5; cfg_enable_us = 16'd9;
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, "R3");
        cfg_cycle_us = 16'd1; cfg_enable_us = 16'd0;
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, "R3");
        cfg_cycle_us = 16'd0; cfg_enable_us = 16'd3;
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, "R3");

        // R7 random settings rewritten mid-burst, random tick gaps
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(0, 30) == 0) begin
                cfg_cycle_us  = W'($urandom_range(0, 12));
                cfg_enable_us = W'($urandom_range(0, 14));
            end
            step($urandom_range(0, 2) == 0, 1'b0, 1'b0, "R7");
        end

        // R1 reset in mid-burst clears counters
        cfg_cycle_us = 16'd6; cfg_enable_us = 16'd3;
        do_reset();
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0, "R1");

        // R11 ticks in external mode while idle, then R5/R6 random triggers
        @(negedge clk); rst = 1; ext_mode = 1;
        do_reset();
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, "R11");
        chk("R11", "idle ext gate", int'(burst_gate), 0);
        cfg_cycle_us = 16'd8; cfg_enable_us = 16'd4;
        step(1'b0, 1'b1, 1'b0, "R5");
        chk("R5", "gate after ext edge", int'(burst_gate), 1);
        step(1'b1, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b0, "R6");
        chk("R6", "no retrigger while open", int'(burst_trig), 0);
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(0, 40) == 0) begin
                cfg_cycle_us  = W'($urandom_range(0, 10));
                cfg_enable_us = W'($urandom_range(0, 10));
            end
            step($urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0, 1'b0, "R5");
        end

        // R10 pattern-position sync
        sync_pat_mode = 1;
        step(1'b0, 1'b0, 1'b0, "R10");
        for (int i = 0; i < 200; i++) step(1'b0, 1'b0, $urandom_range(0, 1) == 1, "R10");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule